// File: doc/BRIEF.md
# Temperature-Sensor Register Target on a Two-Wire Bus

This block is the bus-facing half of a digital temperature sensor. It behaves as an I2C/SMBus target and runs on a fast system clock. SCL and SDA are oversampled through two-flop synchronizers. START and STOP are found as SDA edges while SCL is high. The block pulls SDA low through a single open-drain enable. Behind the bus sits a bank of four 16-bit words, chosen by a pointer: the temperature result, a configuration word, and a low and a high threshold. The pointer is loaded by the first byte of a write. Reads return the word the pointer selects, upper byte first.

The block also answers the general-call address. One command code restores every register and another only re-samples the address straps. It answers the SMBus alert response address with its own address, and the last bit of that byte says whether the event is high or low. If another target wins arbitration, this block backs off. A high-speed master code is refused and only noted. A stuck-bus timer drops an unfinished transaction. The converter loads new temperature results through a strobe. The alert comparator lives outside this block and reports its state on two inputs. The block gives back a register-read pulse, a soft-reset pulse and an alert-won pulse for that logic to use.

Top module: `i2c_temp_target`

## Requirements
- R1: The 7-bit target address is binary 1001 followed by strap_i[2:0], and strap_i is sampled at each START. A matching address byte is acknowledged by pulling SDA low in the ninth clock. Any other address byte is not acknowledged, unless R6, R8 or R10 applies to it.
- R2: After an address with R/W = 0, the next byte is stored as the pointer, and its bits [1:0] pick the word: 0 temperature, 1 configuration, 2 low threshold, 3 high threshold. A read (R/W = 1) sends the selected word upper byte first, then lower byte. The pointer is kept, so reads can repeat without a new pointer write.
- R3: Data bytes after the pointer are acknowledged. The first byte goes into the upper byte of the selected word and the second goes into the lower byte. A STOP after only the first byte leaves the lower byte as it was.
- R4: Configuration bit 15 always reads 0, and bits [7:0] always read FFh. Bits [14:8] are writable. In both threshold words, bits [3:0] always read 0. Writes to pointer 0 (temperature) change nothing.
- R5: After rst_n is released: temperature 0000h, configuration 00FFh, low threshold 4B00h, high threshold 5000h, pointer 0, SDA released, hs_o low.
- R6: Address byte 00h is acknowledged. If the next byte is 06h, it is acknowledged and restores every register and the pointer to their R5 values, and soft_rst_o pulses for one cycle. If this restore lands in the same cycle as a temperature load, the restore wins.
- R7: The general-call command 04h is acknowledged and only re-samples the straps. No register changes and soft_rst_o stays low. An address byte of 01h (general call with R/W = 1) is not acknowledged.
- R8: The alert response byte 19h is acknowledged only while alert_active_i is high. The block then sends {1001, latched straps, alert_high_i}. When that byte is sent in full, alert_won_o pulses for one cycle at the next STOP or START.
- R9: While sending the alert response, if the block releases SDA for a 1 but reads a 0, it stops driving for the rest of the transaction, and alert_won_o does not pulse.
- R10: A first byte matching 00001xxx is not acknowledged and raises hs_o. hs_o stays high across repeated STARTs and falls at the next STOP. Normal addressing keeps working while hs_o is high.
- R11: If SCL or SDA stays low for TMO_CYC clocks between START and STOP, SDA is released. The block then ignores the bus until a new START.
- R12: rd_strobe_o pulses for exactly one cycle for each acknowledged read address of this target. It does not pulse for writes.
- R13: A high on temp_load_i stores {temp_i, 4'h0} into the temperature word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 3 | Low three address bits |
| temp_i | input | 12 | New temperature result, two's complement |
| temp_load_i | input | 1 | Store temp_i into the temperature word |
| alert_active_i | input | 1 | Alert condition present |
| alert_high_i | input | 1 | Alert caused by the high threshold |
| temp_o | output | 16 | Temperature word |
| cfg_o | output | 16 | Configuration word |
| tlow_o | output | 16 | Low threshold word |
| thigh_o | output | 16 | High threshold word |
| rd_strobe_o | output | 1 | One-cycle pulse per register read |
| soft_rst_o | output | 1 | One-cycle pulse on general-call reset |
| alert_won_o | output | 1 | One-cycle pulse after a won alert response |
| hs_o | output | 1 | High-speed master code seen since last STOP |

## Verification
A general-call restore can fall in the same clock edge as a temperature load from the converter. The bench holds temp_load_i high with a non-zero value through the whole reset transaction, and lowers it on the first falling clock edge where soft_rst_o is seen high. So load and restore are both present at the edge that applies the restore. The temperature word must then read 0000h, both at the port and over the bus through the pointer, which the restore has set back to 0.

// File: rtl/i2c_temp_target.sv
module i2c_temp_target #(
  parameter logic [3:0] ADDR_HI = 4'b1001,
  parameter int         TMO_CYC = 13_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  strap_i,
  input  logic [11:0] temp_i,
  input  logic        temp_load_i,
  input  logic        alert_active_i,
  input  logic        alert_high_i,
  output logic [15:0] temp_o,
  output logic [15:0] cfg_o,
  output logic [15:0] tlow_o,
  output logic [15:0] thigh_o,
  output logic        rd_strobe_o,
  output logic        soft_rst_o,
  output logic        alert_won_o,
  output logic        hs_o
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] TMO_LIM = TW'(TMO_CYC);

  typedef enum logic [2:0] {S_IDLE, S_RECV, S_ACK, S_SEND, S_MACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA, K_GC} kind_t;
  typedef enum logic [1:0] {N_IDLE, N_RECV, N_SEND} nxt_t;

  logic [2:0] scl_s, sda_s;
  logic scl_r, scl_p, sda_r, sda_p;
  logic start, stop, scl_rise, scl_fall;

  st_t   state;
  kind_t kind;
  nxt_t  nxt;
  logic [2:0] bitcnt;
  logic [7:0] shreg;
  logic full, ack_q, busy, tx_ara, ara_hi, bytesel, mack, won_pend;
  logic [1:0] wcnt;
  logic [1:0] ptr;
  logic [2:0] strap_q;
  logic [11:0] temp_q, tlo_q, thi_q;
  logic [6:0] cfg_q;
  logic [TW-1:0] tmo;
  logic tmo_hit;
  logic [7:0] b, ara_byte, tx_first, tx_next;
  logic [15:0] reg_word;

  assign scl_r = scl_s[1];
  assign scl_p = scl_s[2];
  assign sda_r = sda_s[1];
  assign sda_p = sda_s[2];
  assign start    = scl_r & scl_p & sda_p & ~sda_r;
  assign stop     = scl_r & scl_p & ~sda_p & sda_r;
  assign scl_rise = scl_r & ~scl_p;
  assign scl_fall = ~scl_r & scl_p;
  assign tmo_hit  = busy && (tmo == TMO_LIM);

  assign temp_o  = {temp_q, 4'h0};
  assign cfg_o   = {1'b0, cfg_q, 8'hFF};
  assign tlow_o  = {tlo_q, 4'h0};
  assign thigh_o = {thi_q, 4'h0};

  assign b        = {shreg[6:0], sda_r};
  assign ara_byte = {ADDR_HI, strap_q, ara_hi};

  always_comb begin
    case (ptr)
      2'd0:    reg_word = temp_o;
      2'd1:    reg_word = cfg_o;
      2'd2:    reg_word = tlow_o;
      default: reg_word = thigh_o;
    endcase
  end

  assign tx_first = tx_ara ? ara_byte : reg_word[15:8];
  assign tx_next  = bytesel ? reg_word[15:8] : reg_word[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  kind <= K_ADDR;  nxt <= N_IDLE;
      bitcnt <= '0;  shreg <= '0;  full <= 1'b0;  ack_q <= 1'b0;
      busy <= 1'b0;  tx_ara <= 1'b0;  ara_hi <= 1'b0;  bytesel <= 1'b0;
      mack <= 1'b0;  won_pend <= 1'b0;  wcnt <= '0;  ptr <= '0;
      strap_q <= '0;  temp_q <= '0;  cfg_q <= '0;
      tlo_q <= 12'h4B0;  thi_q <= 12'h500;  tmo <= '0;
      sda_oe <= 1'b0;  rd_strobe_o <= 1'b0;  soft_rst_o <= 1'b0;
      alert_won_o <= 1'b0;  hs_o <= 1'b0;
    end else begin
      rd_strobe_o <= 1'b0;
      soft_rst_o  <= 1'b0;
      alert_won_o <= 1'b0;
      if (temp_load_i) temp_q <= temp_i;
      if (busy && (!scl_r || !sda_r)) tmo <= tmo + 1'b1;
      else tmo <= '0;

      if (start) begin
        state <= S_RECV;  kind <= K_ADDR;  bitcnt <= '0;  full <= 1'b0;
        sda_oe <= 1'b0;  strap_q <= strap_i;  busy <= 1'b1;  tmo <= '0;
        alert_won_o <= won_pend;  won_pend <= 1'b0;
      end else if (stop) begin
        state <= S_IDLE;  sda_oe <= 1'b0;  busy <= 1'b0;  hs_o <= 1'b0;
        alert_won_o <= won_pend;  won_pend <= 1'b0;
      end else if (tmo_hit) begin
        state <= S_IDLE;  sda_oe <= 1'b0;  busy <= 1'b0;
        won_pend <= 1'b0;  tmo <= '0;
      end else begin
        case (state)
          S_RECV: begin
            if (scl_rise) begin
              shreg  <= b;
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                full  <= 1'b1;
                ack_q <= 1'b1;
                nxt   <= N_RECV;
                case (kind)
                  K_ADDR: begin
                    if (b[7:1] == {ADDR_HI, strap_q}) begin
                      if (b[0]) begin
                        nxt <= N_SEND;  tx_ara <= 1'b0;  bytesel <= 1'b0;
                        rd_strobe_o <= 1'b1;
                      end else begin
                        kind <= K_PTR;
                      end
                    end else if (b == 8'h00) begin
                      kind <= K_GC;
                    end else if (b == 8'h19 && alert_active_i) begin
                      nxt <= N_SEND;  tx_ara <= 1'b1;  ara_hi <= alert_high_i;
                    end else begin
                      ack_q <= 1'b0;
                      nxt   <= N_IDLE;
                      if (b[7:3] == 5'b00001) hs_o <= 1'b1;
                    end
                  end
                  K_PTR: begin
                    ptr  <= b[1:0];
                    kind <= K_DATA;
                    wcnt <= 2'd0;
                  end
                  K_DATA: begin
                    if (wcnt == 2'd0) begin
                      wcnt <= 2'd1;
                      case (ptr)
                        2'd1:    cfg_q <= b[6:0];
                        2'd2:    tlo_q[11:4] <= b;
                        2'd3:    thi_q[11:4] <= b;
                        default: ;
                      endcase
                    end else if (wcnt == 2'd1) begin
                      wcnt <= 2'd2;
                      case (ptr)
                        2'd2:    tlo_q[3:0] <= b[7:4];
                        2'd3:    thi_q[3:0] <= b[7:4];
                        default: ;
                      endcase
                    end
                  end
                  default: begin
                    nxt <= N_IDLE;
                    if (b == 8'h06) begin
                      temp_q <= '0;  cfg_q <= '0;  tlo_q <= 12'h4B0;
                      thi_q <= 12'h500;  ptr <= '0;  soft_rst_o <= 1'b1;
                    end else if (b == 8'h04) begin
                      strap_q <= strap_i;
                    end
                  end
                endcase
              end
            end else if (scl_fall && full) begin
              full   <= 1'b0;
              state  <= S_ACK;
              sda_oe <= ack_q;
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              case (nxt)
                N_RECV: state <= S_RECV;
                N_SEND: begin
                  state  <= S_SEND;
                  shreg  <= tx_first;
                  sda_oe <= ~tx_first[7];
                end
                default: state <= S_IDLE;
              endcase
            end
          end
          S_SEND: begin
            if (scl_rise && tx_ara && shreg[7] && !sda_r) begin
              state  <= S_IDLE;
              sda_oe <= 1'b0;
            end else if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                state  <= S_MACK;
                sda_oe <= 1'b0;
                if (tx_ara) won_pend <= 1'b1;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
                bitcnt <= bitcnt + 3'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_r;
            end else if (scl_fall) begin
              if (mack && !tx_ara) begin
                state   <= S_SEND;
                bytesel <= ~bytesel;
                bitcnt  <= '0;
                shreg   <= tx_next;
                sda_oe  <= ~tx_next[7];
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  soft_rst_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (temp_o == 16'h0000 && cfg_o == 16'h00FF &&
                    tlow_o == 16'h4B00 && thigh_o == 16'h5000));
  // R11
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !start && !stop) |=> (!sda_oe && !busy));
  // R12
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_o |=> !rd_strobe_o);
  // R9
  arb_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEND && tx_ara && scl_rise && shreg[7] && !sda_r &&
     !start && !stop && !tmo_hit) |=> !sda_oe);
  // R1
  drive_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy);
  // R10
  hs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !hs_o);
endmodule

// File: tb/sim_i2c_temp_target.sv
module sim_i2c_temp_target;
  localparam int Q = 10;
  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic [2:0] strap = 3'b101;
  logic [11:0] temp_in = '0;
  logic temp_ld = 0, al_act = 0, al_hi = 0;
  logic sda_oe, rd_s, srst, won, hs;
  logic [15:0] temp_o, cfg_o, tlow_o, thigh_o;
  wire sda_bus = sda_m & ~sda_oe;
  int n = 0, fails = 0, won_cnt = 0, rd_cnt = 0, srst_cnt = 0;
  localparam logic [7:0] ADW = 8'h9A, ADR = 8'h9B;

  always #2 clk = ~clk;

  i2c_temp_target #(.TMO_CYC(3000)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap), .temp_i(temp_in), .temp_load_i(temp_ld),
    .alert_active_i(al_act), .alert_high_i(al_hi),
    .temp_o(temp_o), .cfg_o(cfg_o), .tlow_o(tlow_o), .thigh_o(thigh_o),
    .rd_strobe_o(rd_s), .soft_rst_o(srst), .alert_won_o(won), .hs_o(hs));

  always @(negedge clk) begin
    if (won) won_cnt++;
    if (rd_s) rd_cnt++;
    if (srst) srst_cnt++;
  end

  task automatic tick(input int k); repeat (k) @(posedge clk); endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bstart;
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic bstop;
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(1); sda_m = d[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
    tick(1); sda_m = 1; tick(Q); scl_m = 1; tick(Q);
    @(negedge clk) ack = ~sda_bus;
    tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic rbyte(input logic mack, input logic pull7, output logic [7:0] d);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      if (pull7 && i == 7) sda_m = 0;
      tick(Q); scl_m = 1; tick(Q);
      @(negedge clk) d[i] = sda_bus;
      tick(Q); scl_m = 0; tick(1); sda_m = 1; tick(Q);
    end
    sda_m = ~mack; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(1); sda_m = 1; tick(Q);
  endtask

  task automatic wr_reg(input logic [1:0] p, input logic [7:0] hi, input logic [7:0] lo, input int nb);
    logic a;
    bstart; wbyte(ADW, a); wbyte({6'd0, p}, a);
    if (nb > 0) wbyte(hi, a);
    if (nb > 1) wbyte(lo, a);
    bstop;
  endtask
  task automatic rd_cur(output logic [15:0] w);
    logic a;
    bstart; wbyte(ADR, a); rbyte(1, 0, w[15:8]); rbyte(0, 0, w[7:0]); bstop;
  endtask
  task automatic rd_reg(input logic [1:0] p, output logic [15:0] w);
    logic a;
    bstart; wbyte(ADW, a); wbyte({6'd0, p}, a);
    bstart; wbyte(ADR, a); rbyte(1, 0, w[15:8]); rbyte(0, 0, w[7:0]); bstop;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R5 temp", temp_o, 16'h0000);
    chk("R5 cfg", cfg_o, 16'h00FF);
    chk("R5 tlow", tlow_o, 16'h4B00);
    chk("R5 thigh", thigh_o, 16'h5000);
    chk("R5 sda/hs", {14'd0, sda_oe, hs}, 16'h0);
  endtask

  task automatic t_addr;
    logic a; logic [15:0] w;
    bstart; wbyte(8'h98, a); bstop;
    chk("R1 wrong address nack", {15'd0, a}, 16'h0);
    bstart; strap = 3'b000; wbyte(ADW, a); bstop;
    chk("R1 straps latched at start ack", {15'd0, a}, 16'h1);
    bstart; wbyte(ADW, a); bstop;
    chk("R1 new straps take effect", {15'd0, a}, 16'h0);
    strap = 3'b101;
    rd_reg(2'd3, w);
    chk("R2 read high threshold", w, 16'h5000);
  endtask

  task automatic t_ptr_temp;
    logic [15:0] w;
    temp_in = 12'h190; @(negedge clk) temp_ld = 1; @(negedge clk) temp_ld = 0;
    chk("R13 temp load port", temp_o, 16'h1900);
    rd_reg(2'd0, w);
    chk("R13 temp read over bus", w, 16'h1900);
    wr_reg(2'd2, 8'h12, 8'h34, 2);
    rd_reg(2'd2, w);
    chk("R2 low threshold readback", w, 16'h1230);
    rd_cur(w);
    chk("R2 repeat read keeps pointer", w, 16'h1230);
  endtask

  task automatic t_fields;
    logic [15:0] w;
    wr_reg(2'd1, 8'hFF, 8'h12, 2);
    @(negedge clk) chk("R4 cfg port", cfg_o, 16'h7FFF);
    rd_reg(2'd1, w);
    chk("R4 cfg bus", w, 16'h7FFF);
    wr_reg(2'd3, 8'hAB, 8'hCD, 2);
    @(negedge clk) chk("R4 thigh low nibble", thigh_o, 16'hABC0);
    wr_reg(2'd0, 8'h12, 8'h34, 2);
    @(negedge clk) chk("R4 temp write ignored", temp_o, 16'h1900);
    wr_reg(2'd3, 8'h22, 8'h00, 1);
    @(negedge clk) chk("R3 upper byte only", thigh_o, 16'h22C0);
  endtask

  task automatic t_gc;
    logic a1, a2; logic [15:0] w; int s0;
    s0 = srst_cnt;
    bstart; wbyte(8'h00, a1); wbyte(8'h04, a2); bstop;
    chk("R7 relatch acks", {14'd0, a1, a2}, 16'h3);
    chk("R7 no register change", thigh_o, 16'h22C0);
    chk("R7 no soft reset", 16'(srst_cnt - s0), 16'h0);
    bstart; wbyte(8'h01, a1); bstop;
    chk("R7 read-direction general call nack", {15'd0, a1}, 16'h0);
    wr_reg(2'd3, 8'h00, 8'h00, 0);
    temp_in = 12'h7FF;
    fork
      begin bstart; wbyte(8'h00, a1); wbyte(8'h06, a2); bstop; end
      begin
        @(negedge clk) temp_ld = 1;
        forever begin @(negedge clk); if (srst) break; end
        temp_ld = 0;
      end
    join
    @(negedge clk);
    chk("R6 reset acks", {14'd0, a1, a2}, 16'h3);
    chk("R6 one soft reset pulse", 16'(srst_cnt - s0), 16'h1);
    chk("R6 restore beats load", temp_o, 16'h0000);
    chk("R6 cfg restored", cfg_o, 16'h00FF);
    chk("R6 thigh restored", thigh_o, 16'h5000);
    chk("R6 tlow restored", tlow_o, 16'h4B00);
    rd_cur(w);
    chk("R6 pointer restored to temperature", w, 16'h0000);
  endtask

  task automatic t_ara;
    logic a; logic [7:0] d; int w0;
    w0 = won_cnt;
    al_act = 0;
    bstart; wbyte(8'h19, a); bstop;
    chk("R8 no ack without alert", {15'd0, a}, 16'h0);
    al_act = 1; al_hi = 1;
    bstart; wbyte(8'h19, a); rbyte(0, 0, d); bstop;
    chk("R8 ack with alert", {15'd0, a}, 16'h1);
    chk("R8 address with high flag", {8'd0, d}, 16'h009B);
    chk("R8 won pulse", 16'(won_cnt - w0), 16'h1);
    al_hi = 0;
    bstart; wbyte(8'h19, a); rbyte(0, 0, d); bstop;
    chk("R8 address with low flag", {8'd0, d}, 16'h009A);
    chk("R8 second won pulse", 16'(won_cnt - w0), 16'h2);
    al_hi = 1;
    bstart; wbyte(8'h19, a); rbyte(0, 1, d); bstop;
    chk("R9 lost arbitration releases", {8'd0, d}, 16'h007F);
    chk("R9 no won pulse on loss", 16'(won_cnt - w0), 16'h2);
    al_act = 0;
  endtask

  task automatic t_hs;
    logic a; logic [15:0] w;
    bstart; wbyte(8'h0A, a);
    chk("R10 master code nack", {15'd0, a}, 16'h0);
    @(negedge clk) chk("R10 hs raised", {15'd0, hs}, 16'h1);
    bstart; wbyte(ADW, a); wbyte(8'h01, a);
    chk("R10 addressing in hs", {15'd0, a}, 16'h1);
    bstart; wbyte(ADR, a); rbyte(1, 0, w[15:8]); rbyte(0, 0, w[7:0]);
    @(negedge clk) chk("R10 hs held over repeated start", {15'd0, hs}, 16'h1);
    bstop;
    @(negedge clk) chk("R10 hs cleared by stop", {15'd0, hs}, 16'h0);
    chk("R10 cfg read in hs", w, 16'h00FF);
  endtask

  task automatic t_tmo;
    logic [15:0] w;
    bstart;
    for (int i = 7; i >= 0; i--) begin
      tick(1); sda_m = ADW[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
    tick(1); sda_m = 1; tick(Q);
    @(negedge clk) chk("R11 ack driven before timeout", {15'd0, sda_oe}, 16'h1);
    tick(3200);
    @(negedge clk) chk("R11 released after timeout", {15'd0, sda_oe}, 16'h0);
    for (int k = 0; k < 9; k++) begin
      scl_m = 1; tick(2*Q); scl_m = 0; tick(2*Q);
    end
    @(negedge clk) chk("R11 ignores clocks until start", {15'd0, sda_oe}, 16'h0);
    bstop;
    rd_reg(2'd2, w);
    chk("R11 works after new start", w, 16'h4B00);
  endtask

  task automatic t_strobe;
    logic [15:0] w; int r0;
    r0 = rd_cnt;
    wr_reg(2'd1, 8'h00, 8'h00, 2);
    chk("R12 no strobe on write", 16'(rd_cnt - r0), 16'h0);
    rd_cur(w);
    rd_cur(w);
    chk("R12 one strobe per read", 16'(rd_cnt - r0), 16'h2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n, fails);
    $finish;
  end

  initial begin
    tick(5); rst_n = 1; tick(5);
    t_reset;
    t_addr;
    t_ptr_temp;
    t_fields;
    t_gc;
    t_ara;
    t_hs;
    t_tmo;
    t_strobe;
    tick(10);
    $display("== %0d vectors applied, %0d miscompares ==", n, fails);
    $finish;
  end
endmodule